// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles control flow while an instruction is still in the decode stage. It takes the sequential address (the fetch address plus four), the 16-bit branch offset, the 26-bit jump field, three decode flags (branch-if-equal, branch-if-not-equal, unconditional jump) and the two register operands. It then produces the address to fetch next. An equality comparator and the target arithmetic sit in decode rather than in execute, so a redirect is known in the same cycle the branch is decoded.

When control flow changes, the block raises a PC-select strobe and a flush strobe. It also owns the fetch/decode pipeline register. On the next clock edge that register is loaded with an all-zero no-op instead of the one instruction that was fetched behind the branch, so a taken branch or jump costs exactly one cycle. The register's ordinary write enable lets a stall hold the decode slot. A flush always overrides such a hold.

Top module: `br_resolve_dec`

## Requirements
- R1: With no flag set, or with a branch whose condition fails, `next_pc` equals `pc_plus4`, and `pc_src` and `flush` are both 0.
- R2: A taken conditional branch sends `next_pc` to `pc_plus4` plus the sign-extended `imm16` shifted left by two, modulo 2^32. Negative offsets move backwards.
- R3: Branch-if-equal (`is_beq`) is taken exactly when `rs_val == rt_val`. Branch-if-not-equal (`is_bne`) is taken exactly when they differ.
- R4: A jump (`is_jmp`) is always taken. Its target is `{pc_plus4[31:28], imm26, 2'b00}`.
- R5: Whenever control flow changes, `pc_src` and `flush` are both 1 in that same cycle, with no register delay. At the following rising edge `ifid_instr` becomes the no-op word 32'h0000_0000.
- R6: A flush takes priority over a hold: with `flush` = 1 and `ifid_we` = 0, `ifid_instr` still becomes the no-op at the next edge.
- R7: Without a flush, `ifid_we` = 1 loads `fetch_instr` into `ifid_instr` at the rising edge, and `ifid_we` = 0 keeps `ifid_instr` unchanged.
- R8: A synchronous active-high `rst` sets `ifid_instr` to the no-op at the rising edge.
- R9: When several flags are set at once, the jump wins over both branches, and branch-if-equal wins over branch-if-not-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_plus4 | input | 32 | Address of the decoded instruction plus four |
| imm16 | input | 16 | Signed word offset of a conditional branch |
| imm26 | input | 26 | Word index field of a jump |
| is_beq | input | 1 | Decoded branch-if-equal |
| is_bne | input | 1 | Decoded branch-if-not-equal |
| is_jmp | input | 1 | Decoded unconditional jump |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| ifid_we | input | 1 | Fetch/decode register write enable (0 = hold for stall) |
| fetch_instr | input | 32 | Instruction word arriving from fetch |
| next_pc | output | 32 | Address to fetch next |
| pc_src | output | 1 | 1 when `next_pc` is a redirect target |
| flush | output | 1 | 1 when the fetched follower must be squashed |
| ifid_instr | output | 32 | Contents of the fetch/decode register |

## Verification
The hardest case to reach from the ports is a redirect that coincides with a stall. Here the flush and the held write enable compete for the decode register in one edge. Random stimulus sets the two operands equal about half the time, so both branch outcomes occur often, and it lowers `ifid_we` on a fraction of cycles. Directed cases then force a taken jump and a taken branch with the write enable low. A second subtle case is the carry out of the target adder and the sign of a negative offset. Directed cases place `pc_plus4` near zero and near the top of the address space to cover both.

// File: rtl/br_pkg.sv
package br_pkg;

  // Which control-flow kind wins the priority among the decode flags
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_BNE  = 2'd1,
    BK_BEQ  = 2'd2,
    BK_JMP  = 2'd3
  } br_kind_e;

endpackage

// File: rtl/br_eq_cmp.sv
module br_eq_cmp #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            equal
);

  localparam int LANES = (XLEN + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] b_pad;
  logic [LANES-1:0] lane_eq;

  always_comb begin
    a_pad = '0;
    b_pad = '0;
    a_pad[XLEN-1:0] = a;
    b_pad[XLEN-1:0] = b;
  end

  // Split the compare into narrow lanes, then AND the lane results
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = ~|(a_pad[g*LANE_W +: LANE_W] ^ b_pad[g*LANE_W +: LANE_W]);
  end

  assign equal = &lane_eq;

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIMM_W = 26
) (
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [IMM_W-1:0]  off_imm,
  input  logic [JIMM_W-1:0] jmp_imm,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   jmp_tgt
);

  localparam int SEXT_W = XLEN - IMM_W - 2;
  localparam int HI_W   = XLEN - JIMM_W - 2;

  logic [XLEN-1:0] off_bytes;

  // Word offset -> byte offset, sign-extended to the address width
  assign off_bytes = {{SEXT_W{off_imm[IMM_W-1]}}, off_imm, 2'b00};
  assign br_tgt    = seq_pc + off_bytes;

  // Region bits come from the sequential address
  assign jmp_tgt   = {seq_pc[XLEN-1 -: HI_W], jmp_imm, 2'b00};

endmodule

// File: rtl/br_decide.sv
module br_decide
  import br_pkg::*;
(
  input  logic     f_beq,
  input  logic     f_bne,
  input  logic     f_jmp,
  input  logic     opnd_eq,
  output br_kind_e kind,
  output logic     taken
);

  always_comb begin
    if (f_jmp)      kind = BK_JMP;
    else if (f_beq) kind = BK_BEQ;
    else if (f_bne) kind = BK_BNE;
    else            kind = BK_NONE;
  end

  always_comb begin
    unique case (kind)
      BK_JMP:  taken = 1'b1;
      BK_BEQ:  taken = opnd_eq;
      BK_BNE:  taken = ~opnd_eq;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_ifid_reg.sv
module br_ifid_reg #(
  parameter int              INSTR_W  = 32,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               squash,
  input  logic               we,
  input  logic [INSTR_W-1:0] d,
  output logic [INSTR_W-1:0] q
);

  // Squash beats a held write; reset beats both
  always_ff @(posedge clk) begin
    if (rst)         q <= NOP_WORD;
    else if (squash) q <= NOP_WORD;
    else if (we)     q <= d;
  end

endmodule

// File: rtl/br_resolve_dec.sv
module br_resolve_dec
  import br_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int JIMM_W  = 26,
  parameter int INSTR_W = 32,
  parameter int LANE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    pc_plus4,
  input  logic [IMM_W-1:0]   imm16,
  input  logic [JIMM_W-1:0]  imm26,
  input  logic               is_beq,
  input  logic               is_bne,
  input  logic               is_jmp,
  input  logic [XLEN-1:0]    rs_val,
  input  logic [XLEN-1:0]    rt_val,
  input  logic               ifid_we,
  input  logic [INSTR_W-1:0] fetch_instr,
  output logic [XLEN-1:0]    next_pc,
  output logic               pc_src,
  output logic               flush,
  output logic [INSTR_W-1:0] ifid_instr
);

  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  logic            opnd_eq;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  br_kind_e        kind;
  logic            taken;

  br_eq_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) u_cmp (
    .a     (rs_val),
    .b     (rt_val),
    .equal (opnd_eq)
  );

  br_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIMM_W(JIMM_W)) u_tgt (
    .seq_pc  (pc_plus4),
    .off_imm (imm16),
    .jmp_imm (imm26),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  br_decide u_dec (
    .f_beq   (is_beq),
    .f_bne   (is_bne),
    .f_jmp   (is_jmp),
    .opnd_eq (opnd_eq),
    .kind    (kind),
    .taken   (taken)
  );

  always_comb begin
    if (!taken)              next_pc = pc_plus4;
    else if (kind == BK_JMP) next_pc = jmp_tgt;
    else                     next_pc = br_tgt;
  end

  assign pc_src = taken;
  assign flush  = taken;

  br_ifid_reg #(.INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_ifid (
    .clk    (clk),
    .rst    (rst),
    .squash (flush),
    .we     (ifid_we),
    .d      (fetch_instr),
    .q      (ifid_instr)
  );

endmodule

// File: rtl/br_resolve_dec_chk.sv
module br_resolve_dec_chk #(
  parameter int XLEN    = 32,
  parameter int JIMM_W  = 26,
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [XLEN-1:0]    pc_plus4,
  input logic [JIMM_W-1:0]  imm26,
  input logic               is_beq,
  input logic               is_bne,
  input logic               is_jmp,
  input logic [XLEN-1:0]    rs_val,
  input logic [XLEN-1:0]    rt_val,
  input logic               ifid_we,
  input logic [INSTR_W-1:0] fetch_instr,
  input logic [XLEN-1:0]    next_pc,
  input logic               pc_src,
  input logic               flush,
  input logic [INSTR_W-1:0] ifid_instr
);

  localparam int HI_W = XLEN - JIMM_W - 2;

  p_seq_r1: assert property (@(posedge clk) disable iff (rst)
    (!pc_src) |-> (next_pc == pc_plus4));

  p_noflag_r1: assert property (@(posedge clk) disable iff (rst)
    (!is_beq && !is_bne && !is_jmp) |-> (!pc_src && !flush));

  p_beq_r3: assert property (@(posedge clk) disable iff (rst)
    (is_beq && !is_jmp) |-> (pc_src == (rs_val == rt_val)));

  p_bne_r3: assert property (@(posedge clk) disable iff (rst)
    (is_bne && !is_beq && !is_jmp) |-> (pc_src == (rs_val != rt_val)));

  p_jmp_r4: assert property (@(posedge clk) disable iff (rst)
    is_jmp |-> (pc_src && next_pc[1:0] == 2'b00 &&
                next_pc[XLEN-1 -: HI_W] == pc_plus4[XLEN-1 -: HI_W] &&
                next_pc[JIMM_W+1:2] == imm26));

  p_flush_nop_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ifid_instr == '0));

  p_flush_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (flush && !ifid_we) |=> (ifid_instr == '0));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!flush && ifid_we) |=> (ifid_instr == $past(fetch_instr)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!flush && !ifid_we) |=> $stable(ifid_instr));

  p_reset_r8: assert property (@(posedge clk)
    $fell(rst) |-> (ifid_instr == '0));

endmodule

bind br_resolve_dec br_resolve_dec_chk #(
  .XLEN(XLEN), .JIMM_W(JIMM_W), .INSTR_W(INSTR_W)
) i_chk (
  .clk(clk), .rst(rst), .pc_plus4(pc_plus4), .imm26(imm26),
  .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
  .rs_val(rs_val), .rt_val(rt_val), .ifid_we(ifid_we),
  .fetch_instr(fetch_instr), .next_pc(next_pc), .pc_src(pc_src),
  .flush(flush), .ifid_instr(ifid_instr)
);

// File: tb/test_br_resolve_dec.sv
module test_br_resolve_dec;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc_plus4;
  logic [15:0] imm16;
  logic [25:0] imm26;
  logic        is_beq, is_bne, is_jmp;
  logic [31:0] rs_val, rt_val;
  logic        ifid_we;
  logic [31:0] fetch_instr;
  logic [31:0] next_pc;
  logic        pc_src, flush;
  logic [31:0] ifid_instr;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [31:0] exp_ifid;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  br_resolve_dec i_br_resolve_dec (
    .clk(clk), .rst(rst), .pc_plus4(pc_plus4), .imm16(imm16), .imm26(imm26),
    .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
    .rs_val(rs_val), .rt_val(rt_val), .ifid_we(ifid_we),
    .fetch_instr(fetch_instr), .next_pc(next_pc), .pc_src(pc_src),
    .flush(flush), .ifid_instr(ifid_instr)
  );

  // Expected redirect decision, from R3, R4, R9
  function automatic bit ref_taken(bit j, bit eq_f, bit ne_f, logic [31:0] a, logic [31:0] b);
    if (j)    return 1'b1;
    if (eq_f) return (a == b);
    if (ne_f) return (a != b);
    return 1'b0;
  endfunction

  // Expected next address, from R1, R2, R4
  function automatic logic [31:0] ref_next(bit tk, bit j, logic [31:0] p4,
                                           logic [15:0] o, logic [25:0] ji);
    logic signed [31:0] off;
    if (!tk) return p4;
    if (j)   return {p4[31:28], ji, 2'b00};
    off = 32'(signed'(o)) * 4;
    return p4 + off;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One decode cycle: drive at negedge, check combinational results before
  // the rising edge, check the decode register just after it.
  task automatic cycle(string req, logic [31:0] p4, logic [15:0] o, logic [25:0] ji,
                       bit eq_f, bit ne_f, bit j, logic [31:0] a, logic [31:0] b,
                       bit we, logic [31:0] fi);
    bit tk;
    @(negedge clk);
    pc_plus4 = p4; imm16 = o; imm26 = ji;
    is_beq = eq_f; is_bne = ne_f; is_jmp = j;
    rs_val = a; rt_val = b; ifid_we = we; fetch_instr = fi;
    tk = ref_taken(j, eq_f, ne_f, a, b);
    #5;
    check({req, " next_pc"}, next_pc, ref_next(tk, j, p4, o, ji));
    check({req, " pc_src"}, {31'b0, pc_src}, {31'b0, tk});
    check({req, " flush"}, {31'b0, flush}, {31'b0, tk});
    if (tk)      exp_ifid = 32'h0;
    else if (we) exp_ifid = fi;
    @(posedge clk);
    #1;
    check({req, " ifid_instr"}, ifid_instr, exp_ifid);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1;
    pc_plus4 = 0; imm16 = 0; imm26 = 0;
    is_beq = 0; is_bne = 0; is_jmp = 0;
    rs_val = 0; rt_val = 0; ifid_we = 1; fetch_instr = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset clears the decode register to the no-op
    check("R8 reset", ifid_instr, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    exp_ifid = 32'h0;

    // R1: plain sequential flow and a load of the decode register (R7)
    cycle("R1 noflag", 32'h0000_1004, 16'h0010, 26'h0, 0, 0, 0, 1, 2, 1, 32'h1111_2222);
    // R3/R2: beq taken forward, then beq not taken
    cycle("R3 beq taken", 32'h0000_2000, 16'h0003, 26'h0, 1, 0, 0, 32'h55, 32'h55, 1, 32'hAAAA_0001);
    cycle("R3 beq not-taken", 32'h0000_2000, 16'h0003, 26'h0, 1, 0, 0, 32'h55, 32'h56, 1, 32'hAAAA_0002);
    // R3: bne taken and not taken
    cycle("R3 bne taken", 32'h0000_3000, 16'h0008, 26'h0, 0, 1, 0, 32'h1, 32'h8000_0001, 1, 32'hBBBB_0001);
    cycle("R3 bne not-taken", 32'h0000_3000, 16'h0008, 26'h0, 0, 1, 0, 32'h7, 32'h7, 1, 32'hBBBB_0002);
    // R2: negative offset backwards, and wrap below zero
    cycle("R2 negative", 32'h0000_4000, 16'hFFFC, 26'h0, 1, 0, 0, 9, 9, 1, 32'hCCCC_0001);
    cycle("R2 wrap low", 32'h0000_0004, 16'hFFFE, 26'h0, 0, 1, 0, 1, 2, 1, 32'hCCCC_0002);
    cycle("R2 wrap high", 32'hFFFF_FFF0, 16'h7FFF, 26'h0, 1, 0, 0, 3, 3, 1, 32'hCCCC_0003);
    // R4: jump keeps the region bits of pc_plus4
    cycle("R4 jump", 32'hA000_0008, 16'h0, 26'h3FF_FFFF, 0, 0, 1, 1, 2, 1, 32'hDDDD_0001);
    cycle("R4 jump low", 32'h5123_4568, 16'hFFFF, 26'h000_0001, 0, 0, 1, 4, 4, 1, 32'hDDDD_0002);
    // R7: hold keeps the register
    cycle("R7 load", 32'h0000_5000, 16'h0, 26'h0, 0, 0, 0, 0, 0, 1, 32'h1234_5678);
    cycle("R7 hold", 32'h0000_5000, 16'h0, 26'h0, 0, 0, 0, 0, 0, 0, 32'h8765_4321);
    // R6: flush beats hold, for a jump and a taken branch
    cycle("R7 load2", 32'h0000_5000, 16'h0, 26'h0, 0, 0, 0, 0, 0, 1, 32'h0F0F_0F0F);
    cycle("R6 jump+hold", 32'h0000_6000, 16'h0, 26'h12_3456, 0, 0, 1, 0, 0, 0, 32'hEEEE_0001);
    cycle("R7 load3", 32'h0000_5000, 16'h0, 26'h0, 0, 0, 0, 0, 0, 1, 32'h0F0F_1111);
    cycle("R6 beq+hold", 32'h0000_6000, 16'h0020, 26'h0, 1, 0, 0, 5, 5, 0, 32'hEEEE_0002);
    // R9: priority among multiple flags
    cycle("R9 jmp over beq", 32'h0000_7000, 16'h0040, 26'h00_0100, 1, 0, 1, 1, 2, 1, 32'h9999_0001);
    cycle("R9 beq over bne", 32'h0000_7000, 16'h0040, 26'h0, 1, 1, 0, 1, 2, 1, 32'h9999_0002);
    cycle("R9 beq over bne eq", 32'h0000_7000, 16'h0040, 26'h0, 1, 1, 0, 6, 6, 1, 32'h9999_0003);

    // Random mix: R1..R7, R9
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      int unsigned sel;
      bit eq_f, ne_f, j;
      a = $urandom;
      b = ($urandom_range(1, 0) == 1) ? a : $urandom;
      sel  = $urandom_range(9, 0);
      eq_f = (sel inside {1, 2, 3, 8});
      ne_f = (sel inside {4, 5, 6, 8});
      j    = (sel == 7) || (sel == 9 && $urandom_range(1, 0) == 1);
      cycle("R1-mix R2 R3 R4 R5 R7 R9 random", $urandom, 16'($urandom), 26'($urandom),
            eq_f, ne_f, j, a, b, ($urandom_range(3, 0) != 0), $urandom);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule